// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial memory front end. It gathers the data bytes of one write sequence into a page-sized staging buffer, then copies them into a byte array during a single internal write window of fixed length. A sequence opens with a start strobe that captures a page number and a starting byte offset. Each data strobe places one byte at the current offset and then advances the offset. The offset wraps inside the page, so a long burst overwrites bytes loaded earlier in the same sequence.

A per-byte valid mask records which page locations the current sequence has touched. On commit, only those locations are written and every other byte of the page keeps its old value. While the write window runs, the block raises a busy flag and ignores every request. An abort strobe ends a sequence without writing, for example after a write-protect rejection. A registered read port gives the front end, and the testbench, access to the array.

Top module: `page_commit_buffer`

## Requirements
- R1: After reset every array byte reads 0xFF, busy is low and rdValid is low.
- R2: seqStart, accepted while not busy, captures pageIn and offsetIn and clears the valid mask. Later changes on pageIn do not move the target page.
- R3: Each accepted loadStrobe stores loadData at the current offset and then steps the offset modulo 64. Going past offset 63 returns to offset 0 of the same page and never reaches the next page.
- R4: When one location is loaded more than once in a sequence, the array receives the value loaded last.
- R5: A commit writes only the page bytes loaded in the current sequence. Every other byte of that page, and every other page, keeps its previous value.
- R6: A commitStrobe accepted during an open sequence raises busy from the next cycle for exactly WRITE_CYCLES cycles. The array takes the new bytes at the clock edge that ends the last busy cycle.
- R7: While busy is high, seqStart, loadStrobe, commitStrobe, abortStrobe and rdReq are ignored, and rdValid stays low in the following cycle.
- R8: abortStrobe closes the open sequence and clears the mask. A later commitStrobe does not raise busy and does not change the array.
- R9: rdReq while not busy returns, in the next cycle, rdValid high and rdData equal to the array byte at rdAddr (address = page*64 + offset).
- R10: loadStrobe and commitStrobe with no open sequence (before any seqStart, or after a commit or abort) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seqStart | input | 1 | Opens a write sequence |
| pageIn | input | PAGE_W | Page number captured by seqStart |
| offsetIn | input | 6 | Starting byte offset captured by seqStart |
| loadStrobe | input | 1 | Loads one data byte |
| loadData | input | 8 | Data byte |
| commitStrobe | input | 1 | Starts the internal write window |
| abortStrobe | input | 1 | Ends the sequence without writing |
| rdReq | input | 1 | Read request |
| rdAddr | input | ADDR_W | Array byte address for a read |
| rdData | output | 8 | Read data |
| rdValid | output | 1 | rdData is valid this cycle |
| busy | output | 1 | Internal write window in progress |

## Verification
A wrong offset or a lost wrap shows up only after the write window closes, as a byte read back at the wrong location or a 0xFF where data should be. A stale valid mask shows up as bytes from an earlier or aborted sequence that reappear in the array. A miscounted write window is visible at once on busy, and it shifts when the first read is accepted, so the per-clock comparison of busy and rdValid against the model reports it within one cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef struct packed {
    logic startSeq;
    logic loadByte;
    logic clearMask;
    logic commitNow;
    logic doRead;
  } pwbStrobes_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int WRITE_CYCLES = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        seqStart,
  input  logic        loadStrobe,
  input  logic        commitStrobe,
  input  logic        abortStrobe,
  input  logic        rdReq,
  output pwbStrobes_t strobes,
  output logic        busy
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic             idle;
  logic             commitGo;

  always_comb begin
    idle              = !busy;
    commitGo          = idle && active && !abortStrobe && !seqStart && commitStrobe;
    strobes.startSeq  = idle && !abortStrobe && seqStart;
    strobes.clearMask = idle && (abortStrobe || seqStart);
    strobes.loadByte  = idle && active && !abortStrobe && !seqStart && !commitStrobe && loadStrobe;
    strobes.commitNow = busy && (cnt == '0);
    strobes.doRead    = idle && rdReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (abortStrobe) begin
      active <= 1'b0;
    end else if (seqStart) begin
      active <= 1'b1;
    end else if (commitGo) begin
      busy   <= 1'b1;
      cnt    <= CNT_W'(WRITE_CYCLES - 1);
      active <= 1'b0;
    end
  end

  // R6: an accepted commit opens the busy window on the next cycle
  p_busy_enter_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && active && commitStrobe && !seqStart && !abortStrobe) |=> busy);

  // R6: the window counts down one step per cycle and never ends early
  p_busy_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  // R8: after an abort, a commit cannot start a window
  p_abort_close_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && abortStrobe) |=> !active);
endmodule

// File: rtl/pwb_data.sv
module pwb_data
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES  = 32
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  pwbStrobes_t                                  strobes,
  input  logic [$clog2(NUM_PAGES)-1:0]                 pageIn,
  input  logic [$clog2(PAGE_BYTES)-1:0]                offsetIn,
  input  logic [7:0]                                   loadData,
  input  logic [$clog2(NUM_PAGES*PAGE_BYTES)-1:0]      rdAddr,
  output logic [7:0]                                   rdData,
  output logic                                         rdValid
);
  localparam int OFF_W     = $clog2(PAGE_BYTES);
  localparam int PAGE_W    = $clog2(NUM_PAGES);
  localparam int NUM_BYTES = NUM_PAGES * PAGE_BYTES;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(PAGE_BYTES - 1);

  logic [PAGE_W-1:0]     page;
  logic [OFF_W-1:0]      offset;
  logic [7:0]            pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [7:0]            mem [NUM_BYTES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      page      <= '0;
      offset    <= '0;
      validMask <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= 8'hFF;
    end else begin
      if (strobes.startSeq) begin
        page   <= pageIn;
        offset <= offsetIn;
      end
      if (strobes.clearMask || strobes.commitNow) begin
        validMask <= '0;
      end else if (strobes.loadByte) begin
        validMask[offset] <= 1'b1;
      end
      if (strobes.loadByte) begin
        pageBuf[offset] <= loadData;
        offset          <= (offset == LAST_OFF) ? '0 : offset + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strobes.commitNow) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (validMask[i]) mem[{page, OFF_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= 8'h00;
    end else begin
      rdValid <= strobes.doRead;
      if (strobes.doRead) rdData <= mem[rdAddr];
    end
  end

  // R3: offset wraps to the page start after the last byte
  p_offset_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadByte && offset == LAST_OFF) |=> (offset == '0));

  // R3: a loaded location is marked for commit
  p_mask_mark_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadByte |=> validMask[$past(offset)]);

  // R5: a fresh sequence, an abort or a finished commit leave no stale marks
  p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clearMask || strobes.commitNow) |=> (validMask == '0));

  // R2: the target page moves only on an accepted sequence start
  p_page_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.startSeq |=> $stable(page));
endmodule

// File: rtl/page_commit_buffer.sv
module page_commit_buffer
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES   = 64,
  parameter int NUM_PAGES    = 32,
  parameter int WRITE_CYCLES = 20,
  localparam int PAGE_W      = $clog2(NUM_PAGES),
  localparam int OFF_W       = $clog2(PAGE_BYTES),
  localparam int ADDR_W      = $clog2(NUM_PAGES * PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              seqStart,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic [OFF_W-1:0]  offsetIn,
  input  logic              loadStrobe,
  input  logic [7:0]        loadData,
  input  logic              commitStrobe,
  input  logic              abortStrobe,
  input  logic              rdReq,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic              busy
);
  pwbStrobes_t strobes;

  pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .seqStart(seqStart), .loadStrobe(loadStrobe),
    .commitStrobe(commitStrobe), .abortStrobe(abortStrobe), .rdReq(rdReq),
    .strobes(strobes), .busy(busy)
  );

  pwb_data #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .pageIn(pageIn),
    .offsetIn(offsetIn), .loadData(loadData), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid)
  );

  // R7: a read presented during the write window is not served
  p_read_blocked_r7: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !rdValid);
endmodule

// File: tb/page_commit_buffer_tb_top.sv
module page_commit_buffer_tb_top;
  localparam int PB = 64;
  localparam int NP = 32;
  localparam int WC = 10;
  localparam int NB = PB * NP;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seqStart = 1'b0;
  logic [4:0]  pageIn = '0;
  logic [5:0]  offsetIn = '0;
  logic        loadStrobe = 1'b0;
  logic [7:0]  loadData = '0;
  logic        commitStrobe = 1'b0;
  logic        abortStrobe = 1'b0;
  logic        rdReq = 1'b0;
  logic [10:0] rdAddr = '0;
  logic [7:0]  rdData;
  logic        rdValid;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  page_commit_buffer #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .WRITE_CYCLES(WC)) dut_i (
    .clk(clk), .rstN(rstN), .seqStart(seqStart), .pageIn(pageIn), .offsetIn(offsetIn),
    .loadStrobe(loadStrobe), .loadData(loadData), .commitStrobe(commitStrobe),
    .abortStrobe(abortStrobe), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdData(rdData), .rdValid(rdValid), .busy(busy)
  );

  // behavioural reference model
  int mMem [NB];
  int mBuf [PB];
  bit mMask [PB];
  int mPage, mOff, mBusyCnt, mRdData;
  bit mActive, mRdValid;

  always @(posedge clk) begin
    if (!rstN) begin
      foreach (mMem[i]) mMem[i] = 255;
      foreach (mMask[i]) mMask[i] = 0;
      mPage = 0; mOff = 0; mBusyCnt = 0; mActive = 0; mRdValid = 0; mRdData = 0;
    end else if (mBusyCnt > 0) begin
      if (mBusyCnt == 1) begin
        for (int i = 0; i < PB; i++) if (mMask[i]) mMem[mPage*PB + i] = mBuf[i];
        foreach (mMask[i]) mMask[i] = 0;
      end
      mBusyCnt = mBusyCnt - 1;
      mRdValid = 0;
    end else begin
      mRdValid = rdReq;
      if (rdReq) mRdData = mMem[rdAddr];
      if (abortStrobe) begin
        foreach (mMask[i]) mMask[i] = 0;
        mActive = 0;
      end else if (seqStart) begin
        mPage = pageIn; mOff = offsetIn; mActive = 1;
        foreach (mMask[i]) mMask[i] = 0;
      end else if (commitStrobe && mActive) begin
        mBusyCnt = WC; mActive = 0;
      end else if (loadStrobe && mActive) begin
        mBuf[mOff] = loadData; mMask[mOff] = 1; mOff = (mOff + 1) % PB;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      check(busy == (mBusyCnt > 0), "R6 busy", busy, mBusyCnt > 0);
      check(rdValid == mRdValid, "R9 rdValid", rdValid, mRdValid);
      if (mRdValid) check(rdData == mRdData[7:0], "R9 rdData", rdData, mRdData);
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic startSeq(input int pg, input int off);
    seqStart = 1; pageIn = 5'(pg); offsetIn = 6'(off); step(); seqStart = 0;
  endtask

  task automatic load(input int d);
    loadStrobe = 1; loadData = 8'(d); step(); loadStrobe = 0;
  endtask

  task automatic commitWait(input string req);
    int n;
    commitStrobe = 1; step(); commitStrobe = 0;
    n = 0;
    while (busy && n < 1000) begin n++; step(); end
    check(n == WC, req, n, WC);
  endtask

  task automatic readExp(input int pg, input int off, input int exp, input string req);
    rdReq = 1; rdAddr = 11'(pg*PB + off); step(); rdReq = 0;
    check(rdValid && rdData == 8'(exp), req, rdData, exp);
  endtask

  initial begin
    #(8*100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    step(); step(); step();
    // R1: reset state
    check(busy == 0 && rdValid == 0, "R1 outputs", {busy, rdValid}, 0);
    rstN = 1; step();
    readExp(0, 0, 8'hFF, "R1 erased");
    readExp(NP-1, PB-1, 8'hFF, "R1 erased last");

    // R3: wrap inside page 3 starting at 60
    startSeq(3, 60);
    for (int i = 0; i < 6; i++) load(8'hA0 + i);
    commitWait("R6 window length");
    readExp(3, 60, 8'hA0, "R3 first byte");
    readExp(3, 0, 8'hA4, "R3 wrapped to page start");
    readExp(3, 1, 8'hA5, "R3 wrapped second");
    readExp(3, 2, 8'hFF, "R5 unloaded byte");
    readExp(4, 0, 8'hFF, "R3 next page untouched");

    // R4: 70 bytes from offset 10 on page 5
    startSeq(5, 10);
    for (int i = 0; i < 70; i++) load(i + 1);
    commitWait("R6 window length");
    readExp(5, 10, 65, "R4 overwritten");
    readExp(5, 15, 70, "R4 last value");
    readExp(5, 16, 7, "R4 not overwritten");
    readExp(5, 9, 64, "R4 wrapped tail");

    // R5: partial reload of page 3
    startSeq(3, 61);
    load(8'h11);
    commitWait("R6 window length");
    readExp(3, 61, 8'h11, "R5 loaded byte");
    readExp(3, 60, 8'hA0, "R5 kept byte");
    readExp(3, 62, 8'hA2, "R5 kept byte");

    // R2: page captured at start only
    startSeq(7, 0);
    pageIn = 5'd8;
    load(8'h22);
    commitWait("R6 window length");
    readExp(7, 0, 8'h22, "R2 latched page");
    readExp(8, 0, 8'hFF, "R2 other page");

    // R7: requests during busy are ignored
    startSeq(9, 0);
    load(8'h33);
    commitStrobe = 1; step(); commitStrobe = 0;
    seqStart = 1; pageIn = 5'd10; offsetIn = 6'd0; step(); seqStart = 0;
    load(8'h44);
    abortStrobe = 1; step(); abortStrobe = 0;
    rdReq = 1; rdAddr = 11'd0; step(); rdReq = 0;
    check(rdValid == 0, "R7 read blocked", rdValid, 0);
    while (busy) step();
    readExp(9, 0, 8'h33, "R7 committed");
    readExp(9, 1, 8'hFF, "R7 load ignored");
    readExp(10, 0, 8'hFF, "R7 start ignored");

    // R10: no open sequence after commit
    load(8'h77);
    commitStrobe = 1; step(); commitStrobe = 0;
    check(busy == 0, "R10 commit ignored", busy, 0);
    readExp(9, 1, 8'hFF, "R10 load ignored");

    // R8: abort discards the sequence
    startSeq(11, 0);
    load(8'h55);
    abortStrobe = 1; step(); abortStrobe = 0;
    commitStrobe = 1; step(); commitStrobe = 0;
    check(busy == 0, "R8 no window after abort", busy, 0);
    readExp(11, 0, 8'hFF, "R8 array unchanged");

    step(); step();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule